// File: doc/BRIEF.md
# Fail-Safe Clock Switchover Controller

This block sits in the slow-clock domain of a clock generator and takes the one-cycle failure pulse raised by a crystal-oscillator monitor. When a failure is accepted, it moves the clock tree onto sources that are known to run. If the master clock is being fed from the PLL while the main clock comes from the crystal, the master clock is first moved back to the main clock. The main clock is then always moved to the internal fast RC oscillator, and that oscillator is switched on even if software had it off.

The block also holds the software-programmed select values. Software loads them with a write strobe during normal operation. From the moment a failure is accepted until software clears the fault, writes are dropped and a fault-output status bit stays high. Each select change is a registered update on a slow-clock edge, which stands in for a glitch-free clock multiplexer.

Top module: `fsco_top`

## Requirements
- R1: After reset, fault_out is 0, main_xtal_sel is 0 (fast RC), mst_src_sel equals the main-clock code 1 and frc_on is 1.
- R2: With no fault pending, a cycle with sw_wr high loads sw_main_xtal, sw_mst_src and sw_frc_on into main_xtal_sel, mst_src_sel and frc_on. The new values appear after that edge.
- R3: If main_xtal_sel is 1 and mst_src_sel is the PLL code 2 when a failure is accepted, mst_src_sel becomes the main-clock code 1 after the second rising edge. The edge that samples the pulse counts as the first.
- R4: On any other accepted failure, main_xtal_sel becomes 0 and frc_on becomes 1 after the second rising edge, counting the sampling edge.
- R5: On the PLL path of R3, main_xtal_sel becomes 0 and frc_on becomes 1 after the third rising edge, counting the sampling edge.
- R6: If main_xtal_sel is 0 when a failure is accepted, mst_src_sel keeps its value, including the PLL code 2.
- R7: fault_out rises on the edge that samples an accepted failure. It stays high until a clear is accepted.
- R8: sw_wr is ignored while fault_out is high, and also in a cycle where fail_pulse is high.
- R9: fault_clr is accepted only once the switchover has finished. It drops fault_out on the next edge, and the selects keep their forced values until software writes them again.
- R10: fault_clr has no effect while no fault is pending or while the switchover is still in progress. fail_pulse has no effect while a fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow RC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fail_pulse | input | 1 | Failure pulse from the oscillator monitor |
| fault_clr | input | 1 | Software clear of a pending fault |
| sw_wr | input | 1 | Software write strobe for the selects |
| sw_main_xtal | input | 1 | Main-clock select to write (1 = crystal) |
| sw_mst_src | input | 2 | Master-clock source code to write (1 = main, 2 = PLL) |
| sw_frc_on | input | 1 | Fast RC enable to write |
| main_xtal_sel | output | 1 | Main-clock select in use (1 = crystal, 0 = fast RC) |
| mst_src_sel | output | 2 | Master-clock source code in use |
| frc_on | output | 1 | Fast RC oscillator enable |
| fault_out | output | 1 | Fault-output status, high while the override is active |

## Verification
A sequencer stuck in a wrong state shows up at the ports within one or two slow edges. A skipped master-force stage leaves mst_src_sel at the PLL code after the third edge. A missing force stage moves main_xtal_sel one edge early or never. A lost fault state lets a write change the selects, or drops fault_out without a clear. The directed tests sample every output once per edge through each switchover, so a timing error of one cycle is reported at the edge where it occurs.

// File: rtl/fsco_pkg.sv
package fsco_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_FORCE_MSTR = 2'd1,
    ST_FORCE_MAIN = 2'd2,
    ST_FAULT      = 2'd3
  } fsco_state_e;
endpackage

// File: rtl/fsco_seq.sv
module fsco_seq
  import fsco_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fail_pulse,
  input  logic        fault_clr,
  input  logic        sw_wr,
  input  logic        main_is_xtal,
  input  logic        mst_is_pll,
  output fsco_state_e state_q,
  output logic        wr_load,
  output logic        force_mstr,
  output logic        force_main
);
  fsco_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (fail_pulse) begin
          if (main_is_xtal && mst_is_pll) state_d = ST_FORCE_MSTR;
          else                            state_d = ST_FORCE_MAIN;
        end
      end
      ST_FORCE_MSTR: state_d = ST_FORCE_MAIN;
      ST_FORCE_MAIN: state_d = ST_FAULT;
      ST_FAULT:      if (fault_clr) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign wr_load    = sw_wr && (state_q == ST_IDLE) && !fail_pulse;
  assign force_mstr = (state_q == ST_FORCE_MSTR);
  assign force_main = (state_q == ST_FORCE_MAIN);

  assert_stage_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FORCE_MSTR) |=> (state_q == ST_FORCE_MAIN));

  assert_clr_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FORCE_MAIN) |=> (state_q == ST_FAULT));
endmodule

// File: rtl/fsco_selregs.sv
module fsco_selregs #(
  parameter int MST_W     = 2,
  parameter int MAIN_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             force_mstr,
  input  logic             force_main,
  input  logic             wr_main_xtal,
  input  logic [MST_W-1:0] wr_mst_src,
  input  logic             wr_frc_on,
  output logic             main_xtal_q,
  output logic [MST_W-1:0] mst_src_q,
  output logic             frc_on_q
);
  localparam logic [MST_W-1:0] MAIN_V = MST_W'(MAIN_CODE);

  logic             main_en, mst_en, frc_en;
  logic             main_d, frc_d;
  logic [MST_W-1:0] mst_d;

  always_comb begin
    main_en = force_main || wr_load;
    frc_en  = force_main || wr_load;
    mst_en  = force_mstr || wr_load;
    main_d  = force_main ? 1'b0 : wr_main_xtal;
    frc_d   = force_main ? 1'b1 : wr_frc_on;
    mst_d   = force_mstr ? MAIN_V : wr_mst_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_xtal_q <= 1'b0;
      frc_on_q    <= 1'b1;
      mst_src_q   <= MAIN_V;
    end else begin
      if (main_en) main_xtal_q <= main_d;
      if (frc_en)  frc_on_q    <= frc_d;
      if (mst_en)  mst_src_q   <= mst_d;
    end
  end

  assert_hold_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_load && !force_mstr && !force_main) |=>
      ($stable(main_xtal_q) && $stable(frc_on_q) && $stable(mst_src_q)));
endmodule

// File: rtl/fsco_top.sv
module fsco_top
  import fsco_pkg::*;
#(
  parameter int MST_W     = 2,
  parameter int MAIN_CODE = 1,
  parameter int PLL_CODE  = 2
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             fail_pulse,
  input  logic             fault_clr,
  input  logic             sw_wr,
  input  logic             sw_main_xtal,
  input  logic [MST_W-1:0] sw_mst_src,
  input  logic             sw_frc_on,
  output logic             main_xtal_sel,
  output logic [MST_W-1:0] mst_src_sel,
  output logic             frc_on,
  output logic             fault_out
);
  localparam logic [MST_W-1:0] PLL_V  = MST_W'(PLL_CODE);
  localparam logic [MST_W-1:0] MAIN_V = MST_W'(MAIN_CODE);

  fsco_state_e state_q;
  logic        wr_load, force_mstr, force_main, mst_is_pll;

  assign mst_is_pll = (mst_src_sel == PLL_V);

  fsco_seq u_seq (
    .clk          (clk_slow),
    .rst_n        (rst_n),
    .fail_pulse   (fail_pulse),
    .fault_clr    (fault_clr),
    .sw_wr        (sw_wr),
    .main_is_xtal (main_xtal_sel),
    .mst_is_pll   (mst_is_pll),
    .state_q      (state_q),
    .wr_load      (wr_load),
    .force_mstr   (force_mstr),
    .force_main   (force_main)
  );

  fsco_selregs #(.MST_W(MST_W), .MAIN_CODE(MAIN_CODE)) u_regs (
    .clk          (clk_slow),
    .rst_n        (rst_n),
    .wr_load      (wr_load),
    .force_mstr   (force_mstr),
    .force_main   (force_main),
    .wr_main_xtal (sw_main_xtal),
    .wr_mst_src   (sw_mst_src),
    .wr_frc_on    (sw_frc_on),
    .main_xtal_q  (main_xtal_sel),
    .mst_src_q    (mst_src_sel),
    .frc_on_q     (frc_on)
  );

  assign fault_out = (state_q != ST_IDLE);

  assert_pll_path_R3: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!fault_out && fail_pulse && main_xtal_sel && mst_is_pll) |=> ##1 (mst_src_sel == MAIN_V));

  assert_pll_path_R5: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!fault_out && fail_pulse && main_xtal_sel && mst_is_pll) |=> ##2 (!main_xtal_sel && frc_on));

  assert_direct_path_R4: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!fault_out && fail_pulse && !(main_xtal_sel && mst_is_pll)) |=> ##1 (!main_xtal_sel && frc_on));

  assert_keep_master_R6: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!fault_out && fail_pulse && !main_xtal_sel) |=> ##1 $stable(mst_src_sel));

  assert_fault_rise_R7: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!fault_out && fail_pulse) |=> fault_out);

  assert_fault_hold_R7: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (fault_out && !fault_clr) |=> fault_out);

  assert_frozen_R8: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (state_q == ST_FAULT && $past(state_q) == ST_FAULT) |->
      ($stable(main_xtal_sel) && $stable(mst_src_sel) && $stable(frc_on)));
endmodule

// File: tb/fsco_top_test.sv
module fsco_top_test;
  logic       clk_slow = 1'b0;
  logic       rst_n;
  logic       fail_pulse, fault_clr, sw_wr, sw_main_xtal, sw_frc_on;
  logic [1:0] sw_mst_src;
  logic       main_xtal_sel, frc_on, fault_out;
  logic [1:0] mst_src_sel;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_slow = ~clk_slow;

  fsco_top uut (
    .clk_slow(clk_slow), .rst_n(rst_n), .fail_pulse(fail_pulse), .fault_clr(fault_clr),
    .sw_wr(sw_wr), .sw_main_xtal(sw_main_xtal), .sw_mst_src(sw_mst_src), .sw_frc_on(sw_frc_on),
    .main_xtal_sel(main_xtal_sel), .mst_src_sel(mst_src_sel), .frc_on(frc_on), .fault_out(fault_out)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic outs(string req, int m, int s, int f, int flt);
    chk({req, " main_xtal_sel"}, int'(main_xtal_sel), m);
    chk({req, " mst_src_sel"}, int'(mst_src_sel), s);
    chk({req, " frc_on"}, int'(frc_on), f);
    chk({req, " fault_out"}, int'(fault_out), flt);
  endtask

  task automatic wr(logic m, logic [1:0] s, logic f);
    sw_wr = 1'b1; sw_main_xtal = m; sw_mst_src = s; sw_frc_on = f;
    @(negedge clk_slow);
    sw_wr = 1'b0;
  endtask

  task automatic pulse_fail();
    fail_pulse = 1'b1;
    @(negedge clk_slow);
    fail_pulse = 1'b0;
  endtask

  task automatic clear();
    fault_clr = 1'b1;
    @(negedge clk_slow);
    fault_clr = 1'b0;
  endtask

  task automatic t_reset();
    outs("R1 reset", 0, 1, 1, 0);
  endtask

  task automatic t_write();
    wr(1'b1, 2'd2, 1'b0);
    outs("R2 write a", 1, 2, 0, 0);
    wr(1'b0, 2'd0, 1'b1);
    outs("R2 write b", 0, 0, 1, 0);
    clear();
    outs("R10 clear idle", 0, 0, 1, 0);
  endtask

  task automatic t_pll_path();
    wr(1'b1, 2'd2, 1'b0);
    pulse_fail();
    outs("R7 pll edge1", 1, 2, 0, 1);
    @(negedge clk_slow);
    outs("R3 pll edge2", 1, 1, 0, 1);
    @(negedge clk_slow);
    outs("R5 pll edge3", 0, 1, 1, 1);
    wr(1'b1, 2'd2, 1'b0);
    outs("R8 write in fault", 0, 1, 1, 1);
    pulse_fail();
    outs("R10 pulse in fault", 0, 1, 1, 1);
    clear();
    outs("R9 cleared", 0, 1, 1, 0);
    wr(1'b1, 2'd1, 1'b0);
    outs("R2 write after clear", 1, 1, 0, 0);
  endtask

  task automatic t_main_path();
    pulse_fail();
    outs("R7 main edge1", 1, 1, 0, 1);
    @(negedge clk_slow);
    outs("R4 main edge2", 0, 1, 1, 1);
    clear();
    outs("R9 cleared main", 0, 1, 1, 0);
  endtask

  task automatic t_keep_pll();
    wr(1'b0, 2'd2, 1'b0);
    pulse_fail();
    outs("R6 edge1", 0, 2, 0, 1);
    @(negedge clk_slow);
    outs("R6 edge2", 0, 2, 1, 1);
    @(negedge clk_slow);
    outs("R6 edge3", 0, 2, 1, 1);
    clear();
  endtask

  task automatic t_write_with_fail();
    wr(1'b1, 2'd1, 1'b0);
    sw_wr = 1'b1; sw_main_xtal = 1'b1; sw_mst_src = 2'd2; sw_frc_on = 1'b0;
    fail_pulse = 1'b1;
    @(negedge clk_slow);
    sw_wr = 1'b0; fail_pulse = 1'b0;
    outs("R8 write dropped on fail", 1, 1, 0, 1);
    @(negedge clk_slow);
    outs("R4 after dropped write", 0, 1, 1, 1);
    clear();
  endtask

  task automatic t_clear_early();
    wr(1'b1, 2'd2, 1'b0);
    pulse_fail();
    fault_clr = 1'b1;
    @(negedge clk_slow);
    outs("R10 clr in force master", 1, 1, 0, 1);
    @(negedge clk_slow);
    fault_clr = 1'b0;
    outs("R10 clr in force main", 0, 1, 1, 1);
    @(negedge clk_slow);
    outs("R10 still faulted", 0, 1, 1, 1);
    clear();
    outs("R9 final clear", 0, 1, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; fail_pulse = 1'b0; fault_clr = 1'b0; sw_wr = 1'b0;
    sw_main_xtal = 1'b0; sw_mst_src = 2'd0; sw_frc_on = 1'b0;
    repeat (3) @(negedge clk_slow);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk_slow);
    t_reset();
    t_write();
    t_pll_path();
    t_main_path();
    t_keep_pll();
    t_write_with_fail();
    t_clear_early();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_slow);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule